// File: doc/BRIEF.md
# Pulse Trigger and Capture Sequencer

This block drives the excitation trigger of an ultrasonic pulser and marks the acquisition window that follows each shot. Software sets the shot parameters in a slow control clock domain: trigger width, delay before capture, number of samples, pause between shots, and the number of shots to take. A start pulse in the same domain launches a run. Settings and the start request are carried into the ADC sample clock domain. All timing is then derived there from one cycle counter that restarts at every trigger rise, so the capture window and its sample index stay locked to the excitation within one sample period.

For each shot the trigger is held high, a programmable delay elapses, and a capture window of a programmed length opens. During the window the current ADC word is passed out together with its index, counted in samples from the start of the window. The shot repeats until the programmed count has been reached. A downstream coherent averager can use the first-shot flag to overwrite instead of accumulate. The shot period is never shorter than a minimum that keeps the pulser at or below its highest trigger rate (100 us at a 200 MHz sample clock by default).

Top module: `shot_sequencer`

## Requirements
- R1: After sample-domain reset, trig, cap_valid, first_shot, busy and done are 0, shot_cnt is 0 and cap_data is 0.
- R2: At the start of each shot, trig is high for exactly max(pw,1) consecutive sample cycles.
- R3: cap_valid rises max(pw,1)+dly cycles after the trigger rise and stays high for max(smp,1) cycles. During that window cap_index runs 0,1,2,... one step per cycle and cap_data equals adc_data in the same cycle. Outside it, cap_data is 0.
- R4: Successive trigger rises of one run are exactly P cycles apart, where P = max(pw'+dly+smp'+pause, MIN_PERIOD) and pw', smp' are the values after the zero-to-one substitution. A short pause is lengthened to give the minimum period.
- R5: A run has max(shots,1) shots. shot_cnt holds the number of completed shots of the current run. first_shot is high only while cap_valid is high in the first shot.
- R6: busy rises together with the first trigger and falls exactly shots*P cycles later. In that same cycle done is high for exactly one cycle. shot_cnt then holds the shot total until the next run.
- R7: A ctl_start pulse while busy is ignored, and settings are latched at start. Changing ctl_* values or pulsing start during a run does not alter that run, and no further trigger follows its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control domain clock |
| ctl_rst_n | input | 1 | Control domain reset, active low |
| smp_clk | input | 1 | ADC sample clock |
| smp_rst_n | input | 1 | Sample domain reset, active low |
| ctl_start | input | 1 | One-cycle start request (control domain) |
| ctl_pw | input | CW | Trigger width in sample cycles |
| ctl_dly | input | CW | Delay from trigger end to capture |
| ctl_smp | input | CW | Capture length in samples |
| ctl_pause | input | CW | Idle cycles after capture |
| ctl_shots | input | NW | Shots per run |
| adc_data | input | DW | Current ADC sample |
| trig | output | 1 | Pulser trigger |
| cap_valid | output | 1 | Capture window active |
| cap_index | output | CW | Sample index within the window |
| cap_data | output | DW | Sample passed through during the window |
| first_shot | output | 1 | Capture belongs to shot 0 |
| shot_cnt | output | NW | Completed shots of the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
The hardest case to reach is a start request and a settings change that arrive while a run is in progress. Both must cross the clock domains and land inside the run, and the proof that they were ignored is only visible in the cycle-level timing of that run and in the quiet after it. The bench launches a run and, at a fixed cycle after the first trigger, starts a concurrent process that rewrites the trigger width and pulses start. It then compares every sample cycle against a model built from the settings that were latched at launch, and it watches for a stray trigger after done. The minimum period is lowered so that both the clamped and the unclamped period paths can be reached in short runs.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Zero settings are taken as one so a shot always has a trigger and a sample.
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Shot period: sum of phases, raised to the pulser-rate floor.
  function automatic int unsigned shot_period(input int unsigned pw, input int unsigned dly,
                                              input int unsigned smp, input int unsigned pause,
                                              input int unsigned floor_cyc);
    int unsigned sum;
    sum = pw + dly + smp + pause;
    return (sum < floor_cyc) ? floor_cyc : sum;
  endfunction
endpackage

// File: rtl/start_xing.sv
module start_xing (
  input  logic ctl_clk,
  input  logic ctl_rst_n,
  input  logic smp_clk,
  input  logic smp_rst_n,
  input  logic ctl_start,
  output logic go
);
  logic tgl_q;
  logic [2:0] s_q;

  always_ff @(posedge ctl_clk or negedge ctl_rst_n)
    if (!ctl_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_q ^ ctl_start;

  always_ff @(posedge smp_clk or negedge smp_rst_n)
    if (!smp_rst_n) s_q <= '0;
    else            s_q <= {s_q[1:0], tgl_q};

  assign go = s_q[2] ^ s_q[1];
endmodule

// File: rtl/cfg_xing.sv
module cfg_xing #(
  parameter int W = 8
) (
  input  logic         smp_clk,
  input  logic         smp_rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] m_q;

  always_ff @(posedge smp_clk or negedge smp_rst_n)
    if (!smp_rst_n) begin
      m_q <= '0;
      q   <= '0;
    end else begin
      m_q <= d;
      q   <= m_q;
    end
endmodule

// File: rtl/shot_timer.sv
module shot_timer #(
  parameter int CW = 16,
  parameter int NW = 8,
  parameter int DW = 12,
  parameter int MIN_PERIOD = 20000,
  localparam int TW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] pw,
  input  logic [CW-1:0] dly,
  input  logic [CW-1:0] smp,
  input  logic [CW-1:0] pause,
  input  logic [NW-1:0] shots,
  input  logic [DW-1:0] adc_data,
  output logic          trig,
  output logic          cap_valid,
  output logic [CW-1:0] cap_index,
  output logic [DW-1:0] cap_data,
  output logic          first_shot,
  output logic [NW-1:0] shot_cnt,
  output logic          busy,
  output logic          done
);
  import seq_pkg::*;

  logic          run;
  logic [TW-1:0] since;
  logic [TW-1:0] pw_l, dly_l, smp_l, per_l;
  logic [NW-1:0] shots_l;
  logic [NW-1:0] shot_num;

  // Named events used by the logic and the assertions.
  logic [TW-1:0] cap_open, cap_close;
  logic          shot_end, run_end, launch;

  assign cap_open  = pw_l + dly_l;
  assign cap_close = cap_open + smp_l;
  assign shot_end  = run && (since == per_l - TW'(1));
  assign run_end   = shot_end && ((shot_num + NW'(1)) == shots_l);
  assign launch    = go && !run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; since <= '0; shot_num <= '0; done <= 1'b0;
      pw_l <= TW'(1); dly_l <= '0; smp_l <= TW'(1); per_l <= TW'(1); shots_l <= NW'(1);
    end else begin
      done <= 1'b0;
      if (launch) begin
        run      <= 1'b1;
        since    <= '0;
        shot_num <= '0;
        pw_l     <= TW'(at_least_one(32'(pw)));
        dly_l    <= TW'(dly);
        smp_l    <= TW'(at_least_one(32'(smp)));
        shots_l  <= NW'(at_least_one(32'(shots)));
        per_l    <= TW'(shot_period(at_least_one(32'(pw)), 32'(dly),
                                    at_least_one(32'(smp)), 32'(pause), MIN_PERIOD));
      end else if (run) begin
        if (shot_end) begin
          since    <= '0;
          shot_num <= shot_num + NW'(1);
          if (run_end) begin
            run  <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          since <= since + TW'(1);
        end
      end
    end

  assign trig       = run && (since < pw_l);
  assign cap_valid  = run && (since >= cap_open) && (since < cap_close);
  assign cap_index  = cap_valid ? CW'(since - cap_open) : '0;
  assign cap_data   = cap_valid ? adc_data : '0;
  assign first_shot = cap_valid && (shot_num == '0);
  assign shot_cnt   = shot_num;
  assign busy       = run;

  // Checker state: cycles since the last trigger rise.
  logic [TW-1:0] gap;
  logic          seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0;
    end else if (trig && !(run && since != '0)) begin
      gap <= TW'(1); seen <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + TW'(1);
    end

  AST_TRIG_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> busy); // R2
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && $past(cap_valid) |-> cap_index == $past(cap_index) + CW'(1)); // R3
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) && seen |-> gap >= TW'(MIN_PERIOD)); // R4
  AST_SHOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> shot_cnt < shots_l); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R6
endmodule

// File: rtl/shot_sequencer.sv
module shot_sequencer #(
  parameter int CW = 16,
  parameter int NW = 8,
  parameter int DW = 12,
  parameter int MIN_PERIOD = 20000,
  localparam int BW = 4 * CW + NW
) (
  input  logic          ctl_clk,
  input  logic          ctl_rst_n,
  input  logic          smp_clk,
  input  logic          smp_rst_n,
  input  logic          ctl_start,
  input  logic [CW-1:0] ctl_pw,
  input  logic [CW-1:0] ctl_dly,
  input  logic [CW-1:0] ctl_smp,
  input  logic [CW-1:0] ctl_pause,
  input  logic [NW-1:0] ctl_shots,
  input  logic [DW-1:0] adc_data,
  output logic          trig,
  output logic          cap_valid,
  output logic [CW-1:0] cap_index,
  output logic [DW-1:0] cap_data,
  output logic          first_shot,
  output logic [NW-1:0] shot_cnt,
  output logic          busy,
  output logic          done
);
  logic          go;
  logic [BW-1:0] cfg_s;

  start_xing u_start (
    .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .smp_clk(smp_clk), .smp_rst_n(smp_rst_n),
    .ctl_start(ctl_start), .go(go)
  );

  cfg_xing #(.W(BW)) u_cfg (
    .smp_clk(smp_clk), .smp_rst_n(smp_rst_n),
    .d({ctl_pw, ctl_dly, ctl_smp, ctl_pause, ctl_shots}), .q(cfg_s)
  );

  shot_timer #(.CW(CW), .NW(NW), .DW(DW), .MIN_PERIOD(MIN_PERIOD)) u_timer (
    .clk(smp_clk), .rst_n(smp_rst_n), .go(go),
    .pw(cfg_s[BW-1 -: CW]), .dly(cfg_s[BW-CW-1 -: CW]), .smp(cfg_s[BW-2*CW-1 -: CW]),
    .pause(cfg_s[BW-3*CW-1 -: CW]), .shots(cfg_s[NW-1:0]),
    .adc_data(adc_data), .trig(trig), .cap_valid(cap_valid), .cap_index(cap_index),
    .cap_data(cap_data), .first_shot(first_shot), .shot_cnt(shot_cnt),
    .busy(busy), .done(done)
  );
endmodule

// File: tb/tb_shot_sequencer.sv
`timescale 1ns/1ps
module tb_shot_sequencer;
  localparam int CW = 16, NW = 8, DW = 12, MINP = 40;

  logic ctl_clk = 0, smp_clk = 0, ctl_rst_n = 0, smp_rst_n = 0, ctl_start = 0;
  logic [CW-1:0] ctl_pw = 0, ctl_dly = 0, ctl_smp = 0, ctl_pause = 0;
  logic [NW-1:0] ctl_shots = 0;
  logic [DW-1:0] adc_data = 0;
  logic trig, cap_valid, first_shot, busy, done;
  logic [CW-1:0] cap_index;
  logic [DW-1:0] cap_data;
  logic [NW-1:0] shot_cnt;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 smp_clk = ~smp_clk;
  always #10  ctl_clk = ~ctl_clk;
  always @(negedge smp_clk) adc_data <= adc_data + 12'd37;

  shot_sequencer #(.CW(CW), .NW(NW), .DW(DW), .MIN_PERIOD(MINP)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 25) $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    @(negedge ctl_clk); ctl_start = 1;
    @(negedge ctl_clk); ctl_start = 0;
  endtask

  task automatic set_cfg(input int pw, input int dl, input int sm, input int pa, input int n);
    ctl_pw = CW'(pw); ctl_dly = CW'(dl); ctl_smp = CW'(sm); ctl_pause = CW'(pa); ctl_shots = NW'(n);
    repeat (3) @(negedge ctl_clk);
  endtask

  // Launches a run and checks every sample cycle against the expected schedule.
  task automatic run_and_check(input int pw, input int dl, input int sm, input int pa,
                               input int n, input bit poke);
    int epw, esm, en, per, w;
    epw = (pw == 0) ? 1 : pw;
    esm = (sm == 0) ? 1 : sm;
    en  = (n == 0) ? 1 : n;
    per = epw + dl + esm + pa;
    if (per < MINP) per = MINP;
    pulse_start();
    w = 0;
    forever begin
      @(negedge smp_clk); #0.5;
      if (trig || w > 60) break;
      w++;
    end
    chk("R7 run launches after start", int'(trig), 1);
    for (int k = 0; k <= en * per + 40; k++) begin
      int off, s;
      bit et, ec;
      if (k > 0) begin @(negedge smp_clk); #0.5; end
      if (poke && k == 10) begin
        ctl_pw = CW'(9);
        fork pulse_start(); join_none
      end
      if (k < en * per) begin
        off = k % per; s = k / per;
        et = off < epw;
        ec = (off >= epw + dl) && (off < epw + dl + esm);
        chk("R2 trig", int'(trig), int'(et));
        chk("R4 period trig position", int'(trig && off == 0), int'(off == 0));
        chk("R3 cap_valid", int'(cap_valid), int'(ec));
        if (ec) begin
          chk("R3 cap_index", int'(cap_index), off - epw - dl);
          chk("R3 cap_data", int'(cap_data), int'(adc_data));
        end else chk("R3 cap_data idle", int'(cap_data), 0);
        chk("R5 first_shot", int'(first_shot), int'(ec && s == 0));
        chk("R5 shot_cnt", int'(shot_cnt), s);
        chk("R6 busy", int'(busy), 1);
        chk("R6 done low", int'(done), 0);
      end else begin
        chk("R6 done strobe", int'(done), int'(k == en * per));
        chk("R6 busy low", int'(busy), 0);
        chk("R7 no stray trig", int'(trig), 0);
        chk("R6 shot total", int'(shot_cnt), en);
      end
    end
  endtask

  task automatic test_reset();
    chk("R1 trig", int'(trig), 0);
    chk("R1 cap_valid", int'(cap_valid), 0);
    chk("R1 first_shot", int'(first_shot), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 shot_cnt", int'(shot_cnt), 0);
    chk("R1 cap_data", int'(cap_data), 0);
  endtask

  task automatic test_clamped_pause();   // R4: 3+5+4+10 = 22 -> 40
    set_cfg(3, 5, 4, 10, 3);
    run_and_check(3, 5, 4, 10, 3, 0);
  endtask

  task automatic test_long_pause_no_delay(); // R4: 2+0+6+50 = 58
    set_cfg(2, 0, 6, 50, 2);
    run_and_check(2, 0, 6, 50, 2, 0);
  endtask

  task automatic test_zero_settings();   // R2 R3 R5: zeros become one
    set_cfg(0, 2, 0, 0, 0);
    run_and_check(0, 2, 0, 0, 0, 0);
  endtask

  task automatic test_busy_start_ignored(); // R7
    set_cfg(4, 3, 5, 1, 3);
    run_and_check(4, 3, 5, 1, 3, 1);
    set_cfg(4, 3, 5, 1, 3);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge ctl_clk);
    ctl_rst_n = 1; smp_rst_n = 1;
    repeat (4) @(negedge smp_clk);
    #0.5;
    test_reset();
    test_clamped_pause();
    test_long_pause_no_delay();
    test_zero_settings();
    test_busy_start_ignored();
    test_clamped_pause();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule